// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block lets an external SPI master read and write a small bank of 16-bit configuration registers. The master selects the block by driving `ss_n` low. It then clocks in a 26-bit frame on `mosi`, sampled on rising `sck`. The frame holds a 9-bit register address (most significant bit first), then a direction bit (1 = write, 0 = read), then 16 data bits.

On a write, the data bits come from the master. Once the last of the 16 bits is taken, the word is stored into the addressed register. On a read, the block drives the register content MSB first on `miso`, changing after each rising `sck` so the master can sample on falling edges. `miso_oe` marks the only cycles in which `miso` should be driven onto the shared line; a pad tri-states it otherwise.

All serial logic runs on `sck` and is asynchronous to the system clock `clk`. Every completed write is passed to the `clk` domain as a one-cycle `wr_valid` pulse, with `wr_addr` and `wr_data` beside it. This output stream has no ready signal and so no back-pressure: the consumer must take each pulse in the cycle it appears. `wr_addr` and `wr_data` keep their value until the next pulse.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset, `wr_valid` and `miso_oe` are 0 and every implemented register reads as 16'h0000.
- R2: The first 9 rising `sck` edges of a frame carry the address MSB first, and the 10th rising edge carries the direction bit (1 = write, 0 = read); different addresses select different registers.
- R3: A write frame stores the 16 data bits (rising edges 11 to 26, MSB first) into the addressed register, where a later read returns them.
- R4: In a read frame, register bit 15-k is on `miso` after rising edge 10+k (k = 0..15), for sampling on the following falling edge.
- R5: `miso_oe` is 1 only in a read frame, from the 10th rising edge until the 26th rising edge; it is 0 during write frames and drops at once when `ss_n` goes high.
- R6: A frame ended by `ss_n` rising before the 26th bit changes no register and yields no `wr_valid` pulse; the next frame decodes from its first bit.
- R7: Each completed write gives exactly one one-cycle `wr_valid` pulse in the `clk` domain, carrying the frame's address and data; `wr_addr` and `wr_data` change only with a pulse.
- R8: Addresses at or above `NUM_REGS` read as 16'h0000, and a write to them stores nothing (it still pulses `wr_valid`); no aliasing onto implemented registers.
- R9: Rising `sck` edges after the 26th in one frame are ignored: no further store, pulse or `miso` drive.
- R10: Read frames never modify a register and never pulse `wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the write-notification stream |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low select; high resets the frame state |
| mosi | input | 1 | Serial data from the master, sampled on rising `sck` |
| miso | output | 1 | Serial read data, launched after rising `sck` |
| miso_oe | output | 1 | Drive enable for `miso` (pad tri-states when 0) |
| wr_valid | output | 1 | One-`clk` pulse per completed write |
| wr_addr | output | 9 | Address of the last completed write |
| wr_data | output | 16 | Data of the last completed write |

## Verification
The bench sends write frames whose data patterns are all-ones, single high bit, single low bit and mixed values. These separate MSB-first from LSB-first handling and show an off-by-one at the data boundary. Reads of several addresses after writes show whether address decode picks the right register. An unimplemented address that shares its low bits with an implemented register shows aliasing. Frames cut short, frames stretched past 26 bits and an aborted read test the bit counter's start, saturation and reset. A behavioural model of the bank, and a queue of expected write notifications, is compared with `miso`, `miso_oe` and every `wr_valid` pulse.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned ADDR_BITS = 9;
  localparam int unsigned DATA_BITS = 16;
  localparam int unsigned BANK_REGS = 8;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW = ADDR_BITS,
  parameter int unsigned DW = DATA_BITS
) (
  input  logic          rst_n,
  input  logic          sck,
  input  logic          ss_n,
  input  logic          mosi,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] bank_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_word,
  output logic          miso,
  output logic          miso_oe
);
  localparam int unsigned FRAME = AW + 1 + DW;
  localparam int unsigned CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] DIR_IDX  = CW'(AW);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME - 1);
  localparam logic [CW-1:0] DONE_IDX = CW'(FRAME);

  logic          frame_rst_n;
  logic [CW-1:0] bit_cnt;
  logic [AW-1:0] addr_q;
  xfer_dir_e     dir_q;
  logic [DW-2:0] data_q;
  logic [DW-1:0] rd_sh;
  logic          oe_q;

  // Deselect or reset clears all frame state
  assign frame_rst_n = rst_n & ~ss_n;

  always_ff @(posedge sck or negedge frame_rst_n) begin
    if (!frame_rst_n) begin
      bit_cnt <= '0;
      addr_q  <= '0;
      dir_q   <= DIR_READ;
      data_q  <= '0;
      rd_sh   <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (bit_cnt != DONE_IDX) bit_cnt <= bit_cnt + CW'(1);
      if (bit_cnt < DIR_IDX) addr_q <= {addr_q[AW-2:0], mosi};
      if (bit_cnt == DIR_IDX) begin
        dir_q <= xfer_dir_e'(mosi);
        if (!mosi) begin
          rd_sh <= rd_data;
          oe_q  <= 1'b1;
        end
      end else if (bit_cnt > DIR_IDX && bit_cnt < DONE_IDX) begin
        if (dir_q == DIR_WRITE) begin
          data_q <= {data_q[DW-3:0], mosi};
        end else begin
          rd_sh <= {rd_sh[DW-2:0], 1'b0};
          if (bit_cnt == LAST_IDX) oe_q <= 1'b0;
        end
      end
    end
  end

  assign bank_addr = addr_q;
  assign wr_en     = ~ss_n & (bit_cnt == LAST_IDX) & (dir_q == DIR_WRITE);
  assign wr_word   = {data_q, mosi};
  assign miso      = rd_sh[DW-1];
  assign miso_oe   = oe_q;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW    = ADDR_BITS,
  parameter int unsigned DW    = DATA_BITS,
  parameter int unsigned NREGS = BANK_REGS
) (
  input  logic          rst_n,
  input  logic          sck,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_word,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] regs_q [NREGS];
  logic [NREGS-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NREGS; g++) begin : g_dec
      assign hit[g] = (addr == AW'(g));
    end
  endgenerate

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREGS; i++) begin
        if (hit[i]) regs_q[i] <= wr_word;
      end
    end
  end

  // AND-OR read mux; no hit yields zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      rd_data = rd_data | (regs_q[i] & {DW{hit[i]}});
    end
  end
endmodule

// File: rtl/spi_wr_sync.sv
module spi_wr_sync
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW    = ADDR_BITS,
  parameter int unsigned DW    = DATA_BITS,
  parameter int unsigned SYNC  = SYNC_DEPTH
) (
  input  logic          rst_n,
  input  logic          sck,
  input  logic          commit,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_data,
  input  logic          clk,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          tog_q;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic [SYNC:0] sync_q;
  logic          pulse;

  // Source side: payload held until the next commit
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      tog_q     <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else if (commit) begin
      tog_q     <= ~tog_q;
      hold_addr <= c_addr;
      hold_data <= c_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-1:0], tog_q};
  end

  assign pulse = sync_q[SYNC-1] ^ sync_q[SYNC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= pulse;
      if (pulse) begin
        wr_addr <= hold_addr;
        wr_data <= hold_data;
      end
    end
  end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int unsigned AW       = ADDR_BITS,
  parameter int unsigned DW       = DATA_BITS,
  parameter int unsigned NUM_REGS = BANK_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic [AW-1:0] bank_addr;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] wr_word;
  logic          wr_en;

  spi_frame_shifter #(.AW(AW), .DW(DW)) u_shift (
    .rst_n    (rst_n),
    .sck      (sck),
    .ss_n     (ss_n),
    .mosi     (mosi),
    .rd_data  (rd_data),
    .bank_addr(bank_addr),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .miso     (miso),
    .miso_oe  (miso_oe)
  );

  spi_reg_bank #(.AW(AW), .DW(DW), .NREGS(NUM_REGS)) u_bank (
    .rst_n  (rst_n),
    .sck    (sck),
    .wr_en  (wr_en),
    .addr   (bank_addr),
    .wr_word(wr_word),
    .rd_data(rd_data)
  );

  spi_wr_sync #(.AW(AW), .DW(DW), .SYNC(SYNC_DEPTH)) u_sync (
    .rst_n   (rst_n),
    .sck     (sck),
    .commit  (wr_en),
    .c_addr  (bank_addr),
    .c_data  (wr_word),
    .clk     (clk),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck,
  input logic          ss_n,
  input logic          mosi,
  input logic          miso_oe,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data
);
  localparam int unsigned FRAME = AW + 1 + DW;
  localparam int unsigned CW    = $clog2(FRAME + 1);

  logic          fr_n;
  logic [CW-1:0] ck_cnt;
  logic          ck_dir;

  assign fr_n = rst_n & ~ss_n;

  // Independent edge count of the current frame
  always_ff @(posedge sck or negedge fr_n) begin
    if (!fr_n) begin
      ck_cnt <= '0;
      ck_dir <= 1'b0;
    end else begin
      if (ck_cnt != CW'(FRAME)) ck_cnt <= ck_cnt + CW'(1);
      if (ck_cnt == CW'(AW)) ck_dir <= mosi;
    end
  end

  a_r5_oe_window: assert property (@(posedge sck) disable iff (!rst_n || ss_n)
    miso_oe |-> (ck_cnt >= CW'(AW + 1) && ck_cnt <= CW'(FRAME - 1)));

  a_r5_no_oe_on_write: assert property (@(posedge sck) disable iff (!rst_n || ss_n)
    (ck_cnt > CW'(AW) && ck_dir) |-> !miso_oe);

  a_r9_quiet_after_frame: assert property (@(posedge sck) disable iff (!rst_n || ss_n)
    (ck_cnt == CW'(FRAME)) |-> !miso_oe);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  a_r7_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr != $past(wr_addr) || wr_data != $past(wr_data)) |-> wr_valid);
endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sck     (sck),
  .ss_n    (ss_n),
  .mosi    (mosi),
  .miso_oe (miso_oe),
  .wr_valid(wr_valid),
  .wr_addr (wr_addr),
  .wr_data (wr_data)
);

// File: tb/tb_spi_cfg_slave.sv
`timescale 1ns/100ps
module tb_spi_cfg_slave;
  localparam int AW = 9;
  localparam int DW = 16;
  localparam int NR = 8;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int vecs = 0, errs = 0;
  bit done = 0;
  logic [DW-1:0] model [NR];
  logic [AW+DW-1:0] exp_q [$];
  logic [AW+DW-1:0] e;

  spi_cfg_slave #(.AW(AW), .DW(DW), .NUM_REGS(NR)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every notification must match the oldest expected write (R7, R6, R10)
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) chk("R6/R10 unexpected wr_valid", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R7 wr_addr/wr_data", {7'd0, wr_addr, wr_data}, {7'd0, e});
      end
    end
  end

  task automatic frame(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d,
                       input int nbits, input string req);
    logic [DW-1:0] cur;
    int idx;
    idx = int'(a);
    cur = (idx < NR) ? model[idx] : '0;
    ss_n = 1'b0;
    #20;
    for (int i = 0; i < nbits; i++) begin
      if (i < AW)              mosi = a[AW-1-i];
      else if (i == AW)        mosi = wr;
      else if (i < AW + 1 + DW) mosi = d[AW+DW-i];
      else                     mosi = ~mosi;
      if (wr && i == AW + DW) exp_q.push_back({a, d});
      #20 sck = 1'b1;
      #12;
      if (!wr && i >= AW && i <= AW + DW - 1) begin
        chk({req, " miso_oe"}, {31'd0, miso_oe}, 1);
        chk({req, " miso bit"}, {31'd0, miso}, {31'd0, cur[AW+DW-1-i]});
      end else begin
        chk({req, " R5 miso_oe idle"}, {31'd0, miso_oe}, 0);
      end
      #8 sck = 1'b0;
    end
    #20 ss_n = 1'b1;
    #2 chk({req, " R5 oe after deselect"}, {31'd0, miso_oe}, 0);
    #38;
    if (wr && nbits >= AW + 1 + DW && idx < NR) model[idx] = d;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    chk("R1 miso_oe in reset", {31'd0, miso_oe}, 0);
    chk("R1 wr_valid in reset", {31'd0, wr_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    frame(9'd3, 0, 16'h0, 26, "R1 reset value");
    frame(9'd0, 0, 16'h0, 26, "R1 reset value");
    frame(9'd3, 1, 16'hA5C3, 26, "R3 write");
    frame(9'd3, 0, 16'h0, 26, "R4 read back");
    frame(9'd0, 1, 16'hFFFF, 26, "R3 write ones");
    frame(9'd7, 1, 16'h0001, 26, "R3 write lsb");
    frame(9'd5, 1, 16'h8000, 26, "R3 write msb");
    frame(9'd1, 1, 16'h7FFE, 26, "R3 write mixed");
    frame(9'd0, 0, 16'h0, 26, "R2 decode addr0");
    frame(9'd7, 0, 16'h0, 26, "R2 decode addr7");
    frame(9'd5, 0, 16'h0, 26, "R2 decode addr5");
    frame(9'd1, 0, 16'h0, 26, "R4 read mixed");
    frame(9'd3, 0, 16'h0, 26, "R10 read unchanged");
    frame(9'd6, 1, 16'h1234, 20, "R6 aborted write");
    frame(9'd6, 0, 16'h0, 26, "R6 no store after abort");
    frame(9'd6, 1, 16'h0F0F, 25, "R6 one bit short");
    frame(9'd6, 0, 16'h0, 26, "R6 still zero");
    frame(9'd6, 1, 16'hC0DE, 26, "R6 fresh frame");
    frame(9'd6, 0, 16'h0, 26, "R6 fresh frame read");
    frame(9'd300, 0, 16'h0, 26, "R8 unimplemented read");
    frame(9'd300, 1, 16'hBEEF, 26, "R8 unimplemented write");
    frame(9'd300, 0, 16'h0, 26, "R8 still zero");
    frame(9'd4, 0, 16'h0, 26, "R8 no alias");
    frame(9'd2, 1, 16'h5A5A, 31, "R9 extra edges write");
    frame(9'd2, 0, 16'h0, 31, "R9 extra edges read");
    frame(9'd5, 0, 16'h0, 15, "R5 aborted read");
    frame(9'd5, 0, 16'h0, 26, "R10 after aborted read");
    repeat (20) @(negedge clk);
    chk("R7 all writes notified", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule